// File: doc/BRIEF.md
# Chained JTAG Instruction Register

This block is the instruction-register scan path of a chip whose test port is shared by the device's own TAP and one embedded processor debug TAP. A single 10-bit instruction scan runs from TDI to TDO, least significant bit first. The low six bits always hold the device instruction. The top four bits normally pass through a placeholder segment whose contents have no effect. Once the device instruction 6'b100000 has been latched, a real 4-bit processor instruction register takes the place of that segment. The scan length stays the same in both modes.

The TAP controller outside the block supplies the TCK clock and the state decodes for capture-IR, shift-IR, update-IR and test-logic-reset. The block returns the serial TDO with its enable, the latched device instruction, the latched processor instruction, a flag for the series connection and a one-hot decode of the processor instruction. A parameter can remove the processor segment entirely. The upper four bits are then always a placeholder.

Top module: `jtag_chain_ir`

## Requirements
- R1: On each rising TCK edge with shift-IR high, the path shifts one place: TDI, then the upper 4-bit segment, then the 6-bit device register, then TDO. After ten shifts, scan bit i is held in path bit i. TDO and tdo_oe_o change on the falling edge: TDO takes bit 0 of the device register, and tdo_oe_o is high while shift-IR is high.
- R2: Capture-IR loads 2'b01 into the two lowest bits of the device register and of the active upper segment, and clears their other bits. The first ten bits on TDO after a capture are therefore 1,0,0,0,0,0,1,0,0,0.
- R3: Update-IR copies scan bits 5:0 to dev_ir_o.
- R4: dev_ir_o, cpu_ir_o and cpu_sel_o keep their values through capture and shift. They change only on update-IR or on test-logic-reset.
- R5: Test-logic-reset sets dev_ir_o to 6'b111111 and cpu_ir_o to 4'b1111. This makes cpu_sel_o equal to 9'b000000001 and drives series_o low.
- R6: series_o is high exactly when dev_ir_o equals 6'b100000.
- R7: While series_o is low, the upper four scan bits pass through the placeholder segment, and an update leaves cpu_ir_o unchanged.
- R8: While series_o is high, update-IR copies scan bits 9:6 to cpu_ir_o. The mode is taken from the device instruction held before the update, not from the one being shifted in.
- R9: cpu_sel_o is one-hot. Bit 0 means bypass (code 4'b1111). Bits 1 to 8 mean debug functions 1 to 8, with codes 0101, 0111, 1001, 1010, 1011, 1100, 1101 and 1110 in that order.
- R10: Each of the seven unassigned processor codes decodes to cpu_sel_o = 9'b000000001, the same as bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| tdi_i | input | 1 | Serial scan input |
| cap_ir_i | input | 1 | TAP is in capture-IR |
| shift_ir_i | input | 1 | TAP is in shift-IR |
| upd_ir_i | input | 1 | TAP is in update-IR |
| tlr_i | input | 1 | TAP is in test-logic-reset |
| tdo_o | output | 1 | Serial scan output, changes on the falling edge |
| tdo_oe_o | output | 1 | TDO drive enable during an instruction shift |
| dev_ir_o | output | DEV_W (6) | Latched device instruction |
| cpu_ir_o | output | 4 | Latched processor instruction |
| cpu_sel_o | output | 9 | One-hot processor instruction decode |
| series_o | output | 1 | Processor register is in the scan path |

## Verification
The bench builds the block with its default values: DEV_W of 6, a series code of 6'b100000 and the processor segment present. With these values it can enter and leave series mode and drive all sixteen processor codes through a real update. It also covers the mode change on the same update as a processor load, in both directions. The variant without a processor segment is not built, so its tied-off outputs are checked only at elaboration.

// File: rtl/jir_pkg.sv
package jir_pkg;
   localparam int CPU_W = 4;
   localparam int N_DBG = 8;
   localparam int SEL_W = N_DBG + 1;
   localparam logic [CPU_W-1:0] OP_BYPASS = 4'b1111;
   // debug function k+1 is selected by DBG_OP[k]
   localparam logic [CPU_W-1:0] DBG_OP [N_DBG] = '{
      4'b0101, 4'b0111, 4'b1001, 4'b1010,
      4'b1011, 4'b1100, 4'b1101, 4'b1110
   };
endpackage

// File: rtl/jir_shift_seg.sv
module jir_shift_seg #(
   parameter int W = 4,
   parameter logic [W-1:0] CAP = 1
) (
   input  logic         tck_i,
   input  logic         tlr_i,
   input  logic         en_i,
   input  logic         cap_i,
   input  logic         shift_i,
   input  logic         si_i,
   output logic         so_o,
   output logic [W-1:0] data_o
);
   logic [W-1:0] sr;

   always_ff @(posedge tck_i) begin
      if (tlr_i)                sr <= CAP;
      else if (en_i && cap_i)   sr <= CAP;
      else if (en_i && shift_i) sr <= {si_i, sr[W-1:1]};
   end

   assign so_o   = sr[0];
   assign data_o = sr;

   a_r2_capture: assert property (@(posedge tck_i) disable iff (tlr_i)
      (en_i && cap_i) |=> (data_o == CAP));
   a_r1_shift: assert property (@(posedge tck_i) disable iff (tlr_i)
      (en_i && shift_i && !cap_i) |=>
         (data_o[W-1] == $past(si_i)) && (data_o[W-2:0] == $past(data_o[W-1:1])));
endmodule

// File: rtl/jir_shadow_reg.sv
module jir_shadow_reg #(
   parameter int W = 4,
   parameter logic [W-1:0] RST = '1
) (
   input  logic         tck_i,
   input  logic         tlr_i,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge tck_i) begin
      if (tlr_i)       q_o <= RST;
      else if (load_i) q_o <= d_i;
   end

   a_r5_reset_value: assert property (@(posedge tck_i)
      tlr_i |=> (q_o == RST));
   a_r4_hold: assert property (@(posedge tck_i) disable iff (tlr_i)
      !load_i |=> $stable(q_o));
   a_r3_load: assert property (@(posedge tck_i) disable iff (tlr_i)
      load_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/jir_cpu_decode.sv
module jir_cpu_decode
   import jir_pkg::*;
(
   input  logic [CPU_W-1:0] code_i,
   output logic [SEL_W-1:0] sel_o
);
   logic [N_DBG-1:0] hit;

   for (genvar k = 0; k < N_DBG; k++) begin : g_dbg
      assign hit[k] = (code_i == DBG_OP[k]);
   end

   // bit 0: bypass, which also absorbs every unassigned code (R10)
   assign sel_o = {hit, ~|hit};
endmodule

// File: rtl/jtag_chain_ir.sv
module jtag_chain_ir
   import jir_pkg::*;
#(
   parameter int DEV_W = 6,
   parameter logic [DEV_W-1:0] SERIES_CODE = 6'b100000,
   parameter bit HAS_CPU = 1'b1
) (
   input  logic             tck_i,
   input  logic             tdi_i,
   input  logic             cap_ir_i,
   input  logic             shift_ir_i,
   input  logic             upd_ir_i,
   input  logic             tlr_i,
   output logic             tdo_o,
   output logic             tdo_oe_o,
   output logic [DEV_W-1:0] dev_ir_o,
   output logic [CPU_W-1:0] cpu_ir_o,
   output logic [SEL_W-1:0] cpu_sel_o,
   output logic             series_o
);
   localparam logic [DEV_W-1:0] DEV_CAP = DEV_W'(1);
   localparam logic [CPU_W-1:0] UP_CAP  = CPU_W'(1);
   localparam logic [DEV_W-1:0] DEV_RST = '1;

   if (DEV_W < 2) begin : g_chk_width
      $error("jtag_chain_ir: DEV_W must be at least 2");
   end
   if (SERIES_CODE == {DEV_W{1'b1}}) begin : g_chk_code
      $error("jtag_chain_ir: SERIES_CODE must differ from device bypass");
   end

   logic             up_so;
   logic             dev_so;
   logic [DEV_W-1:0] dev_data;
   logic             series_q;

   jir_shift_seg #(.W(DEV_W), .CAP(DEV_CAP)) i_dev_seg (
      .tck_i(tck_i), .tlr_i(tlr_i), .en_i(1'b1), .cap_i(cap_ir_i),
      .shift_i(shift_ir_i), .si_i(up_so), .so_o(dev_so), .data_o(dev_data));

   jir_shadow_reg #(.W(DEV_W), .RST(DEV_RST)) i_dev_shadow (
      .tck_i(tck_i), .tlr_i(tlr_i), .load_i(upd_ir_i),
      .d_i(dev_data), .q_o(dev_ir_o));

   if (HAS_CPU) begin : g_cpu
      logic             dum_so;
      logic [CPU_W-1:0] dum_unused;
      logic             cpu_so;
      logic [CPU_W-1:0] cpu_data;

      assign series_q = (dev_ir_o == SERIES_CODE);

      jir_shift_seg #(.W(CPU_W), .CAP(UP_CAP)) i_dummy_seg (
         .tck_i(tck_i), .tlr_i(tlr_i), .en_i(!series_q), .cap_i(cap_ir_i),
         .shift_i(shift_ir_i), .si_i(tdi_i), .so_o(dum_so), .data_o(dum_unused));

      jir_shift_seg #(.W(CPU_W), .CAP(UP_CAP)) i_cpu_seg (
         .tck_i(tck_i), .tlr_i(tlr_i), .en_i(series_q), .cap_i(cap_ir_i),
         .shift_i(shift_ir_i), .si_i(tdi_i), .so_o(cpu_so), .data_o(cpu_data));

      jir_shadow_reg #(.W(CPU_W), .RST(OP_BYPASS)) i_cpu_shadow (
         .tck_i(tck_i), .tlr_i(tlr_i), .load_i(upd_ir_i && series_q),
         .d_i(cpu_data), .q_o(cpu_ir_o));

      jir_cpu_decode i_decode (.code_i(cpu_ir_o), .sel_o(cpu_sel_o));

      assign up_so = series_q ? cpu_so : dum_so;

      a_r9_onehot: assert property (@(posedge tck_i) disable iff (tlr_i)
         $countones(cpu_sel_o) == 1);
      a_r7_placeholder: assert property (@(posedge tck_i) disable iff (tlr_i)
         (upd_ir_i && !series_o) |=> $stable(cpu_ir_o));
   end else begin : g_no_cpu
      logic             dum_so;
      logic [CPU_W-1:0] dum_unused;

      assign series_q = 1'b0;

      jir_shift_seg #(.W(CPU_W), .CAP(UP_CAP)) i_dummy_seg (
         .tck_i(tck_i), .tlr_i(tlr_i), .en_i(1'b1), .cap_i(cap_ir_i),
         .shift_i(shift_ir_i), .si_i(tdi_i), .so_o(dum_so), .data_o(dum_unused));

      assign up_so     = dum_so;
      assign cpu_ir_o  = OP_BYPASS;
      assign cpu_sel_o = SEL_W'(1);
   end

   assign series_o = series_q;

   always_ff @(negedge tck_i) begin
      tdo_o    <= dev_so;
      tdo_oe_o <= shift_ir_i && !tlr_i;
   end
endmodule

// File: tb/test_jtag_chain_ir.sv
module test_jtag_chain_ir;
   localparam logic [5:0] SER = 6'b100000;
   localparam logic [9:0] CAP_STREAM = 10'b0001000001;

   logic tck = 1'b0;
   always #4 tck = ~tck;

   logic tdi = 1'b0, cap = 1'b0, shf = 1'b0, upd = 1'b0, tlr = 1'b1;
   logic       tdo, tdo_oe, series;
   logic [5:0] dev;
   logic [3:0] cpu;
   logic [8:0] sel;

   jtag_chain_ir i_jtag_chain_ir (
      .tck_i(tck), .tdi_i(tdi), .cap_ir_i(cap), .shift_ir_i(shf),
      .upd_ir_i(upd), .tlr_i(tlr), .tdo_o(tdo), .tdo_oe_o(tdo_oe),
      .dev_ir_o(dev), .cpu_ir_o(cpu), .cpu_sel_o(sel), .series_o(series));

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [5:0] dev;
      logic [3:0] cpu;
      logic [8:0] sel;
      logic       series;
      string      rdev;
      string      rcpu;
   } item_t;

   item_t q[$];
   event scan_done;
   logic [9:0] got_tdo;
   logic       got_oe;
   logic [5:0] m_dev = 6'h3F;
   logic [3:0] m_cpu = 4'hF;

   function automatic logic [8:0] exp_sel(logic [3:0] c);
      case (c)
         4'b0101: return 9'b000000010;
         4'b0111: return 9'b000000100;
         4'b1001: return 9'b000001000;
         4'b1010: return 9'b000010000;
         4'b1011: return 9'b000100000;
         4'b1100: return 9'b001000000;
         4'b1101: return 9'b010000000;
         4'b1110: return 9'b100000000;
         default: return 9'b000000001;
      endcase
   endfunction

   task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   // monitor: pops expected items and compares them with the outputs
   initial forever begin
      @(scan_done);
      while (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         chk("R2", "tdo stream", 32'(got_tdo), 32'(CAP_STREAM));
         chk("R1", "tdo_oe during shift", 32'(got_oe), 32'd1);
         chk("R1", "tdo_oe after shift", 32'(tdo_oe), 32'd0);
         chk(it.rdev, "dev_ir", 32'(dev), 32'(it.dev));
         chk(it.rcpu, "cpu_ir", 32'(cpu), 32'(it.cpu));
         chk((it.sel == 9'd1 && it.cpu != 4'hF) ? "R10" : "R9", "cpu_sel",
             32'(sel), 32'(it.sel));
         chk("R6", "series", 32'(series), 32'(it.series));
      end
   end

   // driver: one full instruction scan, optionally ending in update-IR
   task automatic scan(logic [9:0] v, bit do_upd, string rdev, string rcpu);
      item_t it;
      @(posedge tck); #1; cap = 1'b1;
      @(posedge tck); #1; cap = 1'b0; shf = 1'b1; tdi = v[0];
      got_oe = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge tck); #1;
         got_tdo[i] = tdo;
         got_oe = got_oe & tdo_oe;
         if (i < 9) begin
            @(posedge tck); #1; tdi = v[i+1];
         end
      end
      @(posedge tck); #1; shf = 1'b0; upd = do_upd;
      @(posedge tck); #1; upd = 1'b0;
      if (do_upd) begin
         if (m_dev == SER) m_cpu = v[9:6];
         m_dev = v[5:0];
      end
      it.dev = m_dev; it.cpu = m_cpu; it.sel = exp_sel(m_cpu);
      it.series = (m_dev == SER); it.rdev = rdev; it.rcpu = rcpu;
      q.push_back(it);
      @(negedge tck); #1;
      -> scan_done;
   endtask

   task automatic reset_check();
      @(posedge tck); #1; tlr = 1'b1;
      @(posedge tck); #1;
      @(posedge tck); #1; tlr = 1'b0;
      m_dev = 6'h3F; m_cpu = 4'hF;
      @(negedge tck); #1;
      chk("R5", "dev_ir after reset", 32'(dev), 32'h3F);
      chk("R5", "cpu_ir after reset", 32'(cpu), 32'hF);
      chk("R5", "cpu_sel after reset", 32'(sel), 32'h1);
      chk("R5", "series after reset", 32'(series), 32'h0);
      chk("R1", "tdo_oe idle", 32'(tdo_oe), 32'h0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      reset_check();
      scan({4'b1010, 6'b000101}, 1'b1, "R3", "R7");
      scan({4'b0101, SER}, 1'b0, "R4", "R4");
      scan({4'b0011, SER}, 1'b1, "R3", "R8");
      for (int c = 0; c < 16; c++) scan({4'(c), SER}, 1'b1, "R3", "R8");
      scan({4'b1001, 6'b000010}, 1'b1, "R3", "R8");
      scan({4'b0111, SER}, 1'b1, "R3", "R7");
      scan({4'b1100, SER}, 1'b1, "R3", "R8");
      scan({4'b0101, 6'b011011}, 1'b0, "R4", "R4");
      reset_check();
      scan({4'b1101, SER}, 1'b1, "R3", "R7");
      repeat (4) @(posedge tck);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge tck);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end
endmodule